// File: doc/BRIEF.md
# Quasi-Resonant Valley Switching Sequencer

This block decides when the power switch of a flyback converter turns on and off during normal regulation. It receives only digital comparator results: feedback against a count-up threshold and a count-down threshold (each in a low-line and a high-line flavour), feedback against a fast-reset threshold, the zero-crossing detect of the auxiliary winding, a flag telling whether the sensed winding level is high, a line-voltage flag and a current-sense trip. Every one of these passes through a two-flop synchronizer before use.

A slow hysteretic up/down counter holds the valley number at which the switch should close. It is evaluated once per long timebase window. A zero-crossing counter tallies detected falling crossings while the switch is open. The switch closes once the tally reaches the valley target, but never inside the ringing-suppression window and always by the maximum off time. Once closed, the switch opens on a current-sense trip after leading-edge blanking, or at the maximum on time. All durations are cycle counts of the single system clock.

Top module: `qr_valley_seq`

## Requirements
- R1: After reset the gate output is low and the valley target reads 1.
- R2: At the end of an evaluation window in which the selected count-up comparator never went high, the valley target rises by one.
- R3: At the end of a window in which the count-up comparator went high but the selected count-down comparator never did, the valley target is unchanged; it never changes between window ends except through R6.
- R4: At the end of a window in which the selected count-down comparator went high, the valley target falls by one.
- R5: The valley target stays within 1 to 7; a step that would leave this range is dropped.
- R6: The reset comparator forces the valley target to 1 within three cycles of its input rising, and the external force input forces it to 1 on the next clock edge.
- R7: The line flag selects the comparator pair: low selects bit 0 of each threshold bus, high selects bit 1.
- R8: Each falling edge of the zero-crossing input adds one to a tally (saturating at 7) only while the gate is low; the tally clears when the gate turns on; the gate turns on once the tally is at least the valley target.
- R9: After turn-off the gate stays low for at least RS_SHORT_CYC cycles while the level flag is high and at least RS_LONG_CYC cycles while it is low.
- R10: The gate turns on after exactly TOFF_MAX_CYC low cycles when no earlier turn-on condition occurs.
- R11: A current-sense trip is ignored for the first LEB_CYC high cycles, so with the trip held active the gate stays high exactly LEB_CYC cycles.
- R12: The gate turns off after exactly TON_MAX_CYC high cycles when no trip occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| high_line_i | input | 1 | Line flag; high picks the high-line threshold comparators |
| fb_lo_cmp_i | input | 2 | Feedback above count-up threshold; bit 0 low-line, bit 1 high-line |
| fb_hi_cmp_i | input | 2 | Feedback above count-down threshold; bit 0 low-line, bit 1 high-line |
| fb_rst_cmp_i | input | 1 | Feedback above the fast-reset threshold |
| zc_cmp_i | input | 1 | Zero-crossing comparator; a falling edge is one crossing |
| rs_level_i | input | 1 | Sensed winding level high; selects the short suppression window |
| cs_trip_i | input | 1 | Current-sense limit reached |
| vt_force_i | input | 1 | Synchronous request from a neighbour to set the valley target to 1 |
| gate_o | output | 1 | Power switch gate drive |
| valley_target_o | output | 3 | Current valley target, 1 to 7 |

## Verification
The hardest situation to reach is a turn-on that depends on the exact valley count: the tally must be shown to ignore crossings that arrive while the gate is high and to clear on turn-on, and the target must first be walked to a value above one and then frozen. The bench lets the target climb through two up windows, holds it by keeping the count-up comparator high, then hand-places crossings: three during a conduction interval, two after turn-off (gate must stay low), and a third that must close the gate within a few cycles, all well inside the maximum off time.

// File: rtl/qr_valley_pkg.sv
package qr_valley_pkg;

  localparam int VALLEY_MAX = 7;
  localparam int VALLEY_W   = $clog2(VALLEY_MAX + 1);

  typedef logic [VALLEY_W-1:0] valley_t;

  typedef enum logic [1:0] {WIN_UP, WIN_HOLD, WIN_DOWN} win_act_e;
  typedef enum logic {GATE_OFF, GATE_ON} gate_st_e;

  // Decide the counter action from what the feedback did over one window.
  function automatic win_act_e classify_window(input logic crossed_up_thr,
                                               input logic crossed_dn_thr);
    if (!crossed_up_thr) return WIN_UP;
    if (!crossed_dn_thr) return WIN_HOLD;
    return WIN_DOWN;
  endfunction

  // Apply an action with saturation inside 1..VALLEY_MAX.
  function automatic valley_t step_valley(input valley_t cur, input win_act_e act);
    valley_t nxt;
    nxt = cur;
    if (act == WIN_UP && cur < valley_t'(VALLEY_MAX)) nxt = cur + valley_t'(1);
    if (act == WIN_DOWN && cur > valley_t'(1))        nxt = cur - valley_t'(1);
    return nxt;
  endfunction

  // Suppression length picked by the sensed winding level.
  function automatic int suppress_cycles(input logic level_high,
                                         input int short_c, input int long_c);
    return level_high ? short_c : long_c;
  endfunction

endpackage

// File: rtl/qr_sync.sv
module qr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/qr_valley_target.sv
module qr_valley_target
  import qr_valley_pkg::*;
#(
  parameter int EVAL_CYC = 12_000_000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    above_up_i,
  input  logic    above_dn_i,
  input  logic    above_rst_i,
  input  logic    force_i,
  output valley_t valley_o
);
  localparam int EW = $clog2(EVAL_CYC);

  logic [EW-1:0] eval_q;
  logic          eval_tick;
  logic          seen_up_q, seen_dn_q;
  valley_t       valley_q;
  win_act_e      act;

  assign eval_tick = (eval_q == EW'(EVAL_CYC - 1));
  assign act       = classify_window(seen_up_q | above_up_i, seen_dn_q | above_dn_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eval_q    <= '0;
      seen_up_q <= 1'b0;
      seen_dn_q <= 1'b0;
    end else if (eval_tick) begin
      eval_q    <= '0;
      seen_up_q <= 1'b0;
      seen_dn_q <= 1'b0;
    end else begin
      eval_q    <= eval_q + EW'(1);
      seen_up_q <= seen_up_q | above_up_i;
      seen_dn_q <= seen_dn_q | above_dn_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       valley_q <= valley_t'(1);
    else if (above_rst_i || force_i)  valley_q <= valley_t'(1);
    else if (eval_tick)               valley_q <= step_valley(valley_q, act);
  end

  assign valley_o = valley_q;

  a_r5_valley_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    valley_q >= valley_t'(1) && valley_q <= valley_t'(VALLEY_MAX));

  a_r6_forced_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    (above_rst_i || force_i) |=> valley_q == valley_t'(1));

  a_r3_quiet_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval_tick && !above_rst_i && !force_i) |=> $stable(valley_q));

  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_tick && !above_rst_i && !force_i) |=>
      (int'(valley_q) == int'($past(valley_q)) ||
       int'(valley_q) == int'($past(valley_q)) + 1 ||
       int'(valley_q) + 1 == int'($past(valley_q))));
endmodule

// File: rtl/qr_zc_counter.sv
module qr_zc_counter
  import qr_valley_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    zc_lvl_i,
  input  logic    gate_i,
  input  logic    clr_i,
  output valley_t count_o
);
  logic    zc_prev_q;
  logic    zc_fall;
  valley_t count_q;

  assign zc_fall = zc_prev_q & ~zc_lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zc_prev_q <= 1'b0;
    else        zc_prev_q <= zc_lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else if (clr_i)
      count_q <= '0;
    else if (!gate_i && zc_fall && count_q < valley_t'(VALLEY_MAX))
      count_q <= count_q + valley_t'(1);
  end

  assign count_o = count_q;

  a_r8_clear_on_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> count_q == '0);

  a_r8_frozen_while_on: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_i && !clr_i) |=> $stable(count_q));

  a_r8_never_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == valley_t'(VALLEY_MAX) && !clr_i) |=> count_q == valley_t'(VALLEY_MAX));
endmodule

// File: rtl/qr_gate_ctrl.sv
module qr_gate_ctrl
  import qr_valley_pkg::*;
#(
  parameter int RS_SHORT_CYC = 625,
  parameter int RS_LONG_CYC  = 6250,
  parameter int TOFF_MAX_CYC = 10500,
  parameter int LEB_CYC      = 83,
  parameter int TON_MAX_CYC  = 7500
) (
  input  logic    clk,
  input  logic    rst_n,
  input  valley_t zc_count_i,
  input  valley_t valley_i,
  input  logic    rs_high_i,
  input  logic    cs_trip_i,
  output logic    turn_on_o,
  output logic    gate_o
);
  localparam int TMAX = (TOFF_MAX_CYC > TON_MAX_CYC) ? TOFF_MAX_CYC : TON_MAX_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  gate_st_e      st_q;
  logic [TW-1:0] run_q;
  int            rs_lim;
  logic          rs_done, off_expired, leb_done, on_expired;
  logic          turn_on, turn_off;

  always_comb begin
    rs_lim      = suppress_cycles(rs_high_i, RS_SHORT_CYC, RS_LONG_CYC);
    rs_done     = int'(run_q) >= rs_lim - 1;
    off_expired = run_q == TW'(TOFF_MAX_CYC - 1);
    leb_done    = int'(run_q) >= LEB_CYC - 1;
    on_expired  = run_q == TW'(TON_MAX_CYC - 1);
    turn_on     = (st_q == GATE_OFF) &&
                  ((rs_done && zc_count_i >= valley_i) || off_expired);
    turn_off    = (st_q == GATE_ON) && ((leb_done && cs_trip_i) || on_expired);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= GATE_OFF;
      run_q <= '0;
    end else if (turn_on) begin
      st_q  <= GATE_ON;
      run_q <= '0;
    end else if (turn_off) begin
      st_q  <= GATE_OFF;
      run_q <= '0;
    end else if (int'(run_q) < TMAX) begin
      run_q <= run_q + TW'(1);
    end
  end

  assign gate_o    = (st_q == GATE_ON);
  assign turn_on_o = turn_on;

  // Independent run-length counters used only by the checks below.
  int lo_run_q, hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run_q <= 0;
      hi_run_q <= 0;
    end else begin
      lo_run_q <= gate_o ? 0 : ((lo_run_q <= TMAX) ? lo_run_q + 1 : lo_run_q);
      hi_run_q <= gate_o ? ((hi_run_q <= TMAX) ? hi_run_q + 1 : hi_run_q) : 0;
    end
  end

  a_r10_off_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_o |-> lo_run_q < TOFF_MAX_CYC);

  a_r12_on_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> hi_run_q < TON_MAX_CYC);

  a_r11_blanking_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && hi_run_q < LEB_CYC - 1) |=> gate_o);

  a_r9_suppress_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_o && lo_run_q < RS_SHORT_CYC - 1) |=> !gate_o);
endmodule

// File: rtl/qr_valley_seq.sv
module qr_valley_seq
  import qr_valley_pkg::*;
#(
  parameter int EVAL_CYC     = 12_000_000,
  parameter int RS_SHORT_CYC = 625,
  parameter int RS_LONG_CYC  = 6250,
  parameter int TOFF_MAX_CYC = 10500,
  parameter int LEB_CYC      = 83,
  parameter int TON_MAX_CYC  = 7500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       high_line_i,
  input  logic [1:0] fb_lo_cmp_i,
  input  logic [1:0] fb_hi_cmp_i,
  input  logic       fb_rst_cmp_i,
  input  logic       zc_cmp_i,
  input  logic       rs_level_i,
  input  logic       cs_trip_i,
  input  logic       vt_force_i,
  output logic       gate_o,
  output logic [2:0] valley_target_o
);
  localparam int NCMP = 9;
  localparam int NFAM = 2;

  logic [NCMP-1:0]       raw, syn;
  logic                  hl_s, rst_s, zc_s, rs_s, cs_s;
  logic [NFAM-1:0][1:0]  fam_s;
  logic [NFAM-1:0]       sel_above;
  valley_t               valley, zc_count;
  logic                  turn_on, gate;

  assign raw = {high_line_i, fb_lo_cmp_i, fb_hi_cmp_i, fb_rst_cmp_i,
                zc_cmp_i, rs_level_i, cs_trip_i};

  qr_sync #(.W(NCMP), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  assign hl_s     = syn[8];
  assign fam_s[0] = syn[7:6];
  assign fam_s[1] = syn[5:4];
  assign rst_s    = syn[3];
  assign zc_s     = syn[2];
  assign rs_s     = syn[1];
  assign cs_s     = syn[0];

  for (genvar f = 0; f < NFAM; f++) begin : g_line_sel
    assign sel_above[f] = hl_s ? fam_s[f][1] : fam_s[f][0];
  end

  qr_valley_target #(.EVAL_CYC(EVAL_CYC)) u_target (
    .clk(clk), .rst_n(rst_n),
    .above_up_i(sel_above[0]), .above_dn_i(sel_above[1]),
    .above_rst_i(rst_s), .force_i(vt_force_i),
    .valley_o(valley)
  );

  qr_zc_counter u_zc (
    .clk(clk), .rst_n(rst_n), .zc_lvl_i(zc_s), .gate_i(gate),
    .clr_i(turn_on), .count_o(zc_count)
  );

  qr_gate_ctrl #(
    .RS_SHORT_CYC(RS_SHORT_CYC), .RS_LONG_CYC(RS_LONG_CYC),
    .TOFF_MAX_CYC(TOFF_MAX_CYC), .LEB_CYC(LEB_CYC), .TON_MAX_CYC(TON_MAX_CYC)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .zc_count_i(zc_count), .valley_i(valley),
    .rs_high_i(rs_s), .cs_trip_i(cs_s), .turn_on_o(turn_on), .gate_o(gate)
  );

  assign gate_o          = gate;
  assign valley_target_o = valley;

  a_r1_reset_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!gate_o && valley_target_o == 3'd1));
endmodule

// File: tb/qr_valley_seq_bench.sv
module qr_valley_seq_bench;
  localparam int EVAL = 200;
  localparam int RS_S = 6;
  localparam int RS_L = 30;
  localparam int TOFF = 60;
  localparam int LEB  = 5;
  localparam int TON  = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       high_line = 1'b0;
  logic [1:0] fb_lo = 2'b00, fb_hi = 2'b00;
  logic       fb_rst = 1'b0, zc_man = 1'b0, rs = 1'b1, cs = 1'b1, vforce = 1'b0;
  logic       ring_en = 1'b0;
  logic [1:0] ring_ph = 2'b00;
  logic       zc_in, gate;
  logic [2:0] vt;
  int         cyc = 0;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  always @(negedge clk) ring_ph <= ring_ph + 2'd1;
  assign zc_in = ring_en ? ring_ph[1] : zc_man;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  qr_valley_seq #(
    .EVAL_CYC(EVAL), .RS_SHORT_CYC(RS_S), .RS_LONG_CYC(RS_L),
    .TOFF_MAX_CYC(TOFF), .LEB_CYC(LEB), .TON_MAX_CYC(TON), .SYNC_STAGES(2)
  ) u_qr_valley_seq (
    .clk(clk), .rst_n(rst_n), .high_line_i(high_line),
    .fb_lo_cmp_i(fb_lo), .fb_hi_cmp_i(fb_hi), .fb_rst_cmp_i(fb_rst),
    .zc_cmp_i(zc_in), .rs_level_i(rs), .cs_trip_i(cs), .vt_force_i(vforce),
    .gate_o(gate), .valley_target_o(vt)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_mid(input int w);
    while (cyc != EVAL * w + EVAL / 2) @(negedge clk);
  endtask

  task automatic pulse_fb(input logic [1:0] lo, input logic [1:0] hi, input logic r);
    fb_lo = lo; fb_hi = hi; fb_rst = r;
    cycles(4);
    fb_lo = 2'b00; fb_hi = 2'b00; fb_rst = 1'b0;
  endtask

  task automatic measure_low(output int n);
    @(negedge clk);
    while (gate !== 1'b1) @(negedge clk);
    while (gate !== 1'b0) @(negedge clk);
    n = 0;
    while (gate === 1'b0) begin n++; @(negedge clk); end
  endtask

  task automatic measure_high(output int n);
    @(negedge clk);
    while (gate !== 1'b0) @(negedge clk);
    while (gate !== 1'b1) @(negedge clk);
    n = 0;
    while (gate === 1'b1) begin n++; @(negedge clk); end
  endtask

  task automatic zc_pulse();
    zc_man = 1'b1; cycles(2);
    zc_man = 1'b0; cycles(2);
  endtask

  task automatic t_reset();
    cycles(1);
    check("R1 gate after reset", gate, 0);
    check("R1 target after reset", vt, 1);
  endtask

  task automatic t_windows();
    wait_mid(0); check("R1 target in first window", vt, 1);
    wait_mid(1); check("R2 up step", vt, 2);
    wait_mid(2); check("R2 up step", vt, 3);
    pulse_fb(2'b11, 2'b00, 1'b0);
    wait_mid(3); check("R3 hold", vt, 3);
    high_line = 1'b1;
    pulse_fb(2'b01, 2'b00, 1'b0);            // only low-line comparator fires
    wait_mid(4); check("R7 high line ignores bit 0", vt, 4);
    pulse_fb(2'b10, 2'b00, 1'b0);            // high-line comparator fires
    wait_mid(5); check("R7 high line uses bit 1", vt, 4);
    high_line = 1'b0;
    wait_mid(6); check("R2 up step", vt, 5);
    wait_mid(7); check("R2 up step", vt, 6);
    wait_mid(8); check("R2 up step", vt, 7);
    wait_mid(9); check("R5 saturate at 7", vt, 7);
    pulse_fb(2'b11, 2'b11, 1'b0);
    wait_mid(10); check("R4 down step", vt, 6);
    pulse_fb(2'b11, 2'b11, 1'b0);
    wait_mid(11); check("R4 down step", vt, 5);
    fb_lo = 2'b11; fb_hi = 2'b11; fb_rst = 1'b1;
    cycles(3);
    check("R6 reset comparator forces 1", vt, 1);
    fb_lo = 2'b00; fb_hi = 2'b00; fb_rst = 1'b0;
    wait_mid(12); check("R5 saturate at 1", vt, 1);
    wait_mid(13); check("R2 up step from 1", vt, 2);
    vforce = 1'b1; cycles(1); vforce = 1'b0;
    check("R6 external force next edge", vt, 1);
  endtask

  task automatic hold_at_one();
    fb_lo = 2'b11; fb_hi = 2'b00;
    cycles(3);
    vforce = 1'b1; cycles(1); vforce = 1'b0;
    check("R6 force before gate tests", vt, 1);
  endtask

  task automatic t_max_off_leb();
    int n;
    ring_en = 1'b0; zc_man = 1'b0; cs = 1'b1;
    measure_low(n);
    measure_low(n);
    check("R10 max off time", n, TOFF);
    measure_high(n);
    check("R11 blanking sets minimum on time", n, LEB);
  endtask

  task automatic t_max_on();
    int n;
    cs = 1'b0;
    measure_high(n);
    measure_high(n);
    check("R12 max on time", n, TON);
    cs = 1'b1;
  endtask

  task automatic t_suppression();
    int n;
    ring_en = 1'b1; rs = 1'b1; cs = 1'b1;
    measure_low(n);
    measure_low(n);
    check("R9 short suppression", n, RS_S);
    rs = 1'b0;
    measure_low(n);
    measure_low(n);
    check("R9 long suppression", n, RS_L);
    rs = 1'b1; ring_en = 1'b0;
  endtask

  task automatic t_valley_count();
    cs = 1'b0; zc_man = 1'b0; ring_en = 1'b0;
    vforce = 1'b1; cycles(1); vforce = 1'b0;
    fb_lo = 2'b00; fb_hi = 2'b00;
    while (vt != 3'd3) @(negedge clk);
    fb_lo = 2'b11;
    cycles(4);
    check("R2 target walked to 3", vt, 3);
    while (gate !== 1'b0) @(negedge clk);
    while (gate !== 1'b1) @(negedge clk);
    repeat (3) zc_pulse();                    // crossings while gate is high
    while (gate !== 1'b0) @(negedge clk);
    repeat (2) zc_pulse();
    cycles(3);
    check("R8 two crossings below target keep gate low", gate, 0);
    zc_pulse();
    cycles(4);
    check("R8 third crossing turns gate on", gate, 1);
  endtask

  initial begin
    cycles(5);
    rst_n = 1'b1;
    t_reset();
    t_windows();
    hold_at_one();
    t_max_off_leb();
    t_max_on();
    t_suppression();
    t_valley_count();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule